// File: doc/BRIEF.md
# Slave Communication Supervisor and Status Lamp Driver

This block supervises the operating state of a field-bus slave node. A communication watchdog restarts on every strobe issued by the data port or the parameter port. When no strobe follows within a fixed window of millisecond ticks, the watchdog expires and requests a soft reset. The watchdog can be switched off by an enable input.

Every cause of a soft reset is merged into a single one-cycle request pulse. The causes are a watchdog expiry, a received slave-reset or broadcast-reset command, and the start of an externally held-low reset condition. A soft reset is only an output here. It never restarts the watchdog or the lamp blink timer, both of which keep running across it.

Two status lamps show the node condition as a steady or blinking pattern chosen by priority. Blinking is paced by a free-running half-period counter of millisecond ticks, 200 ticks by default, which gives 2.5 Hz.

Watchdog states: `WD_IDLE` (not yet armed), `WD_ARMED` (counting ticks since the last strobe) and `WD_FIRED` (expired). The transitions are:
- IDLE to ARMED on a strobe.
- ARMED to ARMED (count cleared) on a strobe.
- ARMED to FIRED on the expiring tick.
- FIRED to ARMED on a strobe.
- Any state to IDLE while the enable is low.

Lamp states: `LS_OFF` (in reset), `LS_RUN`, `LS_NOCOMM`, `LS_NOADDR`, `LS_FAULT` and `LS_RESET`. After reset the lamp state is re-evaluated on every clock from the priority of the current conditions, so any state can move to any other except `LS_OFF`.

Top module: `slave_supervisor`

## Requirements
- R1: While `rst_n` is low, `led1`, `led2` and `soft_reset` are all 0, so both lamps are dark as in an unpowered node. A lamp output of 1 means the lamp is lit.
- R2: A strobe is `data_strobe` or `param_strobe` high in a sampled cycle, and it restarts the watchdog count. If `TIMEOUT_MS` ticks (default 75) are sampled after the last strobe with no new strobe, the watchdog expires. `soft_reset` is then 1 for exactly the one cycle after the edge that sampled the expiring tick. A strobe and a tick in the same cycle count as a strobe.
- R3: After reset the watchdog stays idle and cannot expire until the first strobe. After it expires it stays expired, without further pulses, until the next strobe re-arms it. While `wd_enable` is low it is idle, cleared and never expires.
- R4: `cmd_reset_slave` or `cmd_reset_bcast` high in a sampled cycle makes `soft_reset` 1 in the following cycle.
- R5: A rising edge of `long_low_reset` produces one `soft_reset` pulse in the following cycle. Holding the input high produces no further pulses.
- R6: A soft-reset pulse changes neither the watchdog count nor the blink timer. An expiry still happens `TIMEOUT_MS` ticks after the last strobe, even with a command reset in between.
- R7: The blink phase starts at 0 after reset and inverts every `BLINK_HALF_MS` sampled ticks, 200 by default. The blink phase drives the pattern of any blinking lamp.
- R8: Regular operation gives `led1`=1 and `led2`=0. An expired watchdog with no higher-priority condition gives `led1`=0 and `led2`=1.
- R9: `addr_zero`=1 gives `led1`=blink phase and `led2`=1.
- R10: `fault_n`=0 gives `led1`=blink phase and `led2`=inverted phase, so the two lamps alternate.
- R11: `long_low_reset`=1 or `out_overload`=1 gives `led1`=0 and `led2`=blink phase.
- R12: The priority runs from highest to lowest: R11, R10, R9, then the expired watchdog, then regular operation. The lamps follow the inputs sampled one clock earlier, and follow the watchdog state one clock after that state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-up reset |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| data_strobe | input | 1 | Data port strobe activity pulse |
| param_strobe | input | 1 | Parameter port strobe activity pulse |
| cmd_reset_slave | input | 1 | Slave-reset command received |
| cmd_reset_bcast | input | 1 | Broadcast-reset command received |
| long_low_reset | input | 1 | Level: strobe line held low long enough to reset |
| fault_n | input | 1 | Peripheral fault, active low |
| out_overload | input | 1 | Field supply overload flag |
| addr_zero | input | 1 | Stored slave address is zero |
| wd_enable | input | 1 | Watchdog enable |
| soft_reset | output | 1 | One-cycle soft-reset request |
| led1 | output | 1 | Lamp 1 drive, 1 = lit |
| led2 | output | 1 | Lamp 2 drive, 1 = lit |

## Verification
The watchdog is tried with four patterns:
- Strobes spaced well inside the window, which must give no expiry.
- Strobes that stop, which must expire at one exact cycle.
- A single strobe after the expiry, which separates re-arming from staying latched.
- An enable held low through a long silence.

Command and held-low reset pulses are placed in the middle of an armed window, which shows whether a soft reset disturbs the watchdog or the blink phase. The fault, zero-address, overload and held-low conditions are applied alone and stacked on each other, and each is held over several blink half-periods. This exposes both the pattern of each lamp state and the priority between them, since every pair of conditions differs in at least one lamp.

// File: rtl/supv_pkg.sv
package supv_pkg;

    typedef enum logic [1:0] {
        WD_IDLE  = 2'd0,
        WD_ARMED = 2'd1,
        WD_FIRED = 2'd2
    } wd_state_t;

    typedef enum logic [2:0] {
        LS_OFF    = 3'd0,
        LS_RUN    = 3'd1,
        LS_NOCOMM = 3'd2,
        LS_NOADDR = 3'd3,
        LS_FAULT  = 3'd4,
        LS_RESET  = 3'd5
    } led_state_t;

endpackage

// File: rtl/comm_watchdog.sv
module comm_watchdog
    import supv_pkg::*;
#(
    parameter int TIMEOUT_MS = 75
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ms_tick,
    input  logic strobe,
    input  logic enable,
    output logic expire,
    output logic fired
);
    localparam int CW = $clog2(TIMEOUT_MS + 1);
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT_MS - 1);

    wd_state_t state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        expire  = 1'b0;
        if (!enable) begin
            state_d = WD_IDLE;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                WD_IDLE: begin
                    if (strobe) begin
                        state_d = WD_ARMED;
                        cnt_d   = '0;
                    end
                end
                WD_ARMED: begin
                    if (strobe) begin
                        cnt_d = '0;
                    end else if (ms_tick) begin
                        if (cnt_q == LAST) begin
                            state_d = WD_FIRED;
                            cnt_d   = '0;
                            expire  = 1'b1;
                        end else begin
                            cnt_d = cnt_q + 1'b1;
                        end
                    end
                end
                WD_FIRED: begin
                    if (strobe) begin
                        state_d = WD_ARMED;
                        cnt_d   = '0;
                    end
                end
                default: begin
                    state_d = WD_IDLE;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WD_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    assign fired = (state_q == WD_FIRED);

    assert_disabled_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !fired);

    assert_strobe_rearms_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && strobe) |=> !fired);

    assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

endmodule

// File: rtl/blink_timer.sv
module blink_timer #(
    parameter int BLINK_HALF_MS = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ms_tick,
    output logic phase
);
    localparam int BW = $clog2(BLINK_HALF_MS + 1);
    localparam logic [BW-1:0] HLAST = BW'(BLINK_HALF_MS - 1);

    logic [BW-1:0] bcnt_q;
    logic          phase_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bcnt_q  <= '0;
            phase_q <= 1'b0;
        end else if (ms_tick) begin
            if (bcnt_q == HLAST) begin
                bcnt_q  <= '0;
                phase_q <= ~phase_q;
            end else begin
                bcnt_q <= bcnt_q + 1'b1;
            end
        end
    end

    assign phase = phase_q;

    assert_phase_on_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !ms_tick |=> $stable(phase_q));

endmodule

// File: rtl/reset_combiner.sv
module reset_combiner (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_reset_slave,
    input  logic cmd_reset_bcast,
    input  logic long_low_reset,
    input  logic wd_expire,
    output logic soft_reset
);
    logic ll_q;
    logic pulse_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ll_q    <= 1'b0;
            pulse_q <= 1'b0;
        end else begin
            ll_q    <= long_low_reset;
            pulse_q <= cmd_reset_slave | cmd_reset_bcast | wd_expire
                     | (long_low_reset & ~ll_q);
        end
    end

    assign soft_reset = pulse_q;

    assert_cmd_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_reset_slave || cmd_reset_bcast) |=> soft_reset);

    assert_ll_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (long_low_reset && !ll_q) |=> soft_reset);

endmodule

// File: rtl/led_status.sv
module led_status
    import supv_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic phase,
    input  logic hold_reset,
    input  logic fault,
    input  logic addr_zero,
    input  logic wd_fired,
    output logic led1,
    output logic led2
);
    led_state_t state_q, state_d;

    always_comb begin
        if (hold_reset)      state_d = LS_RESET;
        else if (fault)      state_d = LS_FAULT;
        else if (addr_zero)  state_d = LS_NOADDR;
        else if (wd_fired)   state_d = LS_NOCOMM;
        else                 state_d = LS_RUN;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LS_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        led1 = 1'b0;
        led2 = 1'b0;
        unique case (state_q)
            LS_OFF:    begin led1 = 1'b0;   led2 = 1'b0;    end
            LS_RUN:    begin led1 = 1'b1;   led2 = 1'b0;    end
            LS_NOCOMM: begin led1 = 1'b0;   led2 = 1'b1;    end
            LS_NOADDR: begin led1 = phase;  led2 = 1'b1;    end
            LS_FAULT:  begin led1 = phase;  led2 = ~phase;  end
            LS_RESET:  begin led1 = 1'b0;   led2 = phase;   end
            default:   begin led1 = 1'b0;   led2 = 1'b0;    end
        endcase
    end

    assert_reset_dark1_R11: assert property (@(posedge clk) disable iff (!rst_n)
        hold_reset |=> !led1);

    assert_fault_alt_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_reset && fault) |=> (led1 != led2));

    assert_noaddr_led2_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_reset && !fault && addr_zero) |=> led2);

endmodule

// File: rtl/slave_supervisor.sv
module slave_supervisor #(
    parameter int TIMEOUT_MS    = 75,
    parameter int BLINK_HALF_MS = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ms_tick,
    input  logic data_strobe,
    input  logic param_strobe,
    input  logic cmd_reset_slave,
    input  logic cmd_reset_bcast,
    input  logic long_low_reset,
    input  logic fault_n,
    input  logic out_overload,
    input  logic addr_zero,
    input  logic wd_enable,
    output logic soft_reset,
    output logic led1,
    output logic led2
);
    logic wd_expire;
    logic wd_fired;
    logic phase;

    comm_watchdog #(.TIMEOUT_MS(TIMEOUT_MS)) u_wd (
        .clk     (clk),
        .rst_n   (rst_n),
        .ms_tick (ms_tick),
        .strobe  (data_strobe | param_strobe),
        .enable  (wd_enable),
        .expire  (wd_expire),
        .fired   (wd_fired)
    );

    blink_timer #(.BLINK_HALF_MS(BLINK_HALF_MS)) u_blink (
        .clk     (clk),
        .rst_n   (rst_n),
        .ms_tick (ms_tick),
        .phase   (phase)
    );

    reset_combiner u_rst (
        .clk             (clk),
        .rst_n           (rst_n),
        .cmd_reset_slave (cmd_reset_slave),
        .cmd_reset_bcast (cmd_reset_bcast),
        .long_low_reset  (long_low_reset),
        .wd_expire       (wd_expire),
        .soft_reset      (soft_reset)
    );

    led_status u_led (
        .clk        (clk),
        .rst_n      (rst_n),
        .phase      (phase),
        .hold_reset (long_low_reset | out_overload),
        .fault      (~fault_n),
        .addr_zero  (addr_zero),
        .wd_fired   (wd_fired),
        .led1       (led1),
        .led2       (led2)
    );

    assert_fire_pulses_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wd_fired) |-> soft_reset);

    assert_reset_dark_R1: assert property (@(posedge clk)
        !rst_n |-> (!led1 && !led2 && !soft_reset));

endmodule

// File: tb/slave_supervisor_bench.sv
`timescale 1ns/1ps
module slave_supervisor_bench;
    localparam int TMO  = 75;
    localparam int HALF = 200;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ms_tick = 1'b0;
    logic data_strobe = 1'b0, param_strobe = 1'b0;
    logic cmd_reset_slave = 1'b0, cmd_reset_bcast = 1'b0;
    logic long_low_reset = 1'b0, fault_n = 1'b1, out_overload = 1'b0;
    logic addr_zero = 1'b0, wd_enable = 1'b1;
    logic soft_reset, led1, led2;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    string tag = "R1";
    bit done = 0;

    always #2 clk = ~clk;

    slave_supervisor #(.TIMEOUT_MS(TMO), .BLINK_HALF_MS(HALF)) u_slave_supervisor (
        .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick),
        .data_strobe(data_strobe), .param_strobe(param_strobe),
        .cmd_reset_slave(cmd_reset_slave), .cmd_reset_bcast(cmd_reset_bcast),
        .long_low_reset(long_low_reset), .fault_n(fault_n),
        .out_overload(out_overload), .addr_zero(addr_zero),
        .wd_enable(wd_enable), .soft_reset(soft_reset),
        .led1(led1), .led2(led2)
    );

    // Behavioural reference: 0 idle, 1 armed, 2 expired
    int  m_wd = 0, m_cnt = 0, m_bcnt = 0;
    bit  m_phase = 0, m_llq = 0, m_soft = 0;
    int  m_lamp = 0; // 0 off 1 run 2 nocomm 3 noaddr 4 fault 5 reset

    always @(posedge clk) begin
        if (!rst_n) begin
            m_wd = 0; m_cnt = 0; m_bcnt = 0; m_phase = 0;
            m_llq = 0; m_soft = 0; m_lamp = 0;
        end else begin
            bit stb, exp_now;
            int nl;
            stb = data_strobe || param_strobe;
            if (long_low_reset || out_overload) nl = 5;
            else if (!fault_n) nl = 4;
            else if (addr_zero) nl = 3;
            else if (m_wd == 2) nl = 2;
            else nl = 1;
            exp_now = wd_enable && m_wd == 1 && !stb && ms_tick && m_cnt == TMO - 1;
            if (!wd_enable) begin m_wd = 0; m_cnt = 0; end
            else if (stb) begin m_wd = 1; m_cnt = 0; end
            else if (m_wd == 1 && ms_tick) begin
                if (m_cnt == TMO - 1) begin m_wd = 2; m_cnt = 0; end
                else m_cnt++;
            end
            m_soft = cmd_reset_slave || cmd_reset_bcast || exp_now ||
                     (long_low_reset && !m_llq);
            m_llq = long_low_reset;
            if (ms_tick) begin
                if (m_bcnt == HALF - 1) begin m_bcnt = 0; m_phase = !m_phase; end
                else m_bcnt++;
            end
            m_lamp = nl;
        end
    end

    function automatic bit [1:0] lamp_exp(int s, bit ph);
        case (s)
            1: return 2'b10;
            2: return 2'b01;
            3: return {ph, 1'b1};
            4: return {ph, !ph};
            5: return {1'b0, ph};
            default: return 2'b00;
        endcase
    endfunction

    always @(negedge clk) begin
        if (!done) begin
            bit [1:0] el;
            el = lamp_exp(m_lamp, m_phase);
            checks++;
            if (soft_reset !== m_soft) begin
                failures++;
                $display("FAIL %s cycle %0d soft_reset actual=%b expected=%b", tag, cyc, soft_reset, m_soft);
            end
            checks++;
            if ({led1, led2} !== el) begin
                failures++;
                $display("FAIL %s cycle %0d leds actual=%b%b expected=%b", tag, cyc, led1, led2, el);
            end
            cyc++;
            #1 ms_tick = (cyc % 2 == 0);
        end
    end

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
        #1;
    endtask

    task automatic pulse(ref logic s);
        s = 1'b1; idle(1); s = 1'b0;
    endtask

    task automatic strobes(int count, int gap);
        for (int i = 0; i < count; i++) begin
            if (i % 2 == 0) pulse(data_strobe); else pulse(param_strobe);
            idle(gap);
        end
    endtask

    initial begin
        #1;
        tag = "R1"; idle(6);
        rst_n = 1'b1;
        tag = "R3"; idle(400);                 // no strobe yet: no expiry
        tag = "R8"; strobes(8, 40);            // regular operation
        tag = "R2"; idle(400);                 // silence: expiry and no-comm lamps
        tag = "R3"; idle(200);                 // latched, no second pulse
        pulse(data_strobe); idle(100);         // re-arm
        wd_enable = 1'b0; idle(400);           // disabled: no expiry
        wd_enable = 1'b1;
        tag = "R4"; strobes(2, 20);
        pulse(cmd_reset_slave); idle(3);
        pulse(cmd_reset_bcast); idle(3);
        cmd_reset_slave = 1'b1; cmd_reset_bcast = 1'b1; idle(2);
        cmd_reset_slave = 1'b0; cmd_reset_bcast = 1'b0;
        tag = "R6"; pulse(param_strobe); idle(60);
        pulse(cmd_reset_slave); idle(60);
        pulse(cmd_reset_bcast); idle(200);     // expiry still at its time
        tag = "R5"; long_low_reset = 1'b1; idle(30);
        long_low_reset = 1'b0; idle(10);
        long_low_reset = 1'b1; idle(3); long_low_reset = 1'b0; idle(5);
        tag = "R9"; addr_zero = 1'b1; idle(900);
        tag = "R10"; fault_n = 1'b0; idle(900);
        tag = "R11"; out_overload = 1'b1; idle(900);
        tag = "R12"; out_overload = 1'b0; idle(5);
        fault_n = 1'b1; idle(5);
        addr_zero = 1'b0; idle(5);
        tag = "R7"; strobes(20, 40);
        tag = "R11"; long_low_reset = 1'b1; fault_n = 1'b0; idle(500);
        long_low_reset = 1'b0; fault_n = 1'b1;
        tag = "R12"; addr_zero = 1'b1; fault_n = 1'b0; idle(20);
        fault_n = 1'b1; addr_zero = 1'b0; idle(20);
        tag = "R1"; rst_n = 1'b0; idle(4);
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #200000;
        failures++;
        checks++;
        $display("FAIL watchdog timeout actual=hung expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule